// File: doc/BRIEF.md
# Packed 9-bit Column Unpacker

This block expands a column of densely packed 9-bit codes into 32-bit lanes. Input words are 128 bits wide. The codes form one continuous bit stream: code i sits at stream bits 9i to 9i+8. Stream bit 128w+j is bit j of the w-th input word of the column. Each output beat carries four consecutive codes, each zero-extended to 32 bits. Both sides use a valid/ready handshake.

Inside, the input words go into a byte-aligned bit buffer, so codes that cross a word boundary come out intact. Each beat passes the low buffer bytes through three steps:
- A byte-selector shuffle copies two source bytes into the low half of each lane and zeroes the upper half.
- Each lane gets its own left shift, so that all four codes sit at the same bit offset.
- One common right shift and a 9-bit mask finish all four lanes.

The selectors and shift amounts come from the bit offset, modulo 8, at which the current group starts. An end-of-column flag on the last input word makes the block flush a final partial group. A lane-valid mask marks which lanes hold codes.

Top module: `col_unpack9`

## Requirements
- R1: Lane k of the g-th beat of a column, at `out_lanes[32k+31:32k]`, holds code 4g+k of that column, zero-extended. Code i is the 9-bit field at stream bits 9i..9i+8, and stream bit 128w+j is bit j of input word w. Bits 31:9 of every lane are zero.
- R2: A code whose 9 bits span two input words is decoded the same as any other code.
- R3: `out_valid` is asserted only when at least 36 unconsumed column bits are buffered, or when the column has ended and at least 9 bits remain. No beat is produced beyond the codes the column contains.
- R4: After the word carrying `in_last` is accepted, `in_ready` stays low until the beat with `out_last` has been taken.
- R5: The final beat of a column carries floor(remaining bits / 9) codes and has `out_last` = 1. Fewer than 9 leftover bits are discarded. Every other beat has `out_last` = 0.
- R6: `out_lane_vld` bit k is 1 when lane k holds a code, so the mask is 0001, 0011, 0111 or 1111. Lanes whose bit is 0 read as zero.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_lanes` does not change.
- R8: After reset, `out_valid` is 0 and `in_ready` is 1.
- R9: A column whose length is a multiple of 36 bits ends on a full beat: mask 1111 with `out_last` = 1.
- R10: Each new column starts decoding at bit 0 of its first word. Leftover bits of the previous column have no effect, and `in_ready` returns to 1 once a column has drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 128 | Packed code bits, first bit of the stream in bit 0 |
| in_last | input | 1 | Marks the final word of a column |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_lanes | output | 128 | Four 32-bit lanes, lane 0 in the low bits |
| out_lane_vld | output | 4 | Per-lane code present flag |
| out_last | output | 1 | Final beat of the column |

## Verification
The hardest case to reach is a group that starts in the middle of a byte: a group at buffer offset 4 whose top code also crosses an input-word seam, taken while the consumer is stalling. That case needs the buffer's fill level, the group phase and the backpressure to line up at the same time. The stimulus runs columns of 1, 2, 3, 5 and 9 words with idle gaps between input words and random `out_ready` stalls, so that both phases of the group offset meet word boundaries under backpressure. The column lengths are chosen so the final beat is exact, holds 2 codes or holds 3 codes.

// File: rtl/cu9_pkg.sv
package cu9_pkg;
    localparam int DEF_IN_W   = 128;
    localparam int DEF_CODE_W = 9;
    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 32;
    localparam int DEF_BUF_W  = 192;
    // Selector byte value that forces a destination byte to zero.
    localparam logic [7:0] SEL_ZERO = 8'hFF;
endpackage

// File: rtl/cu9_lane_plan.sv
// Derives byte selectors and shift amounts for one group from its bit phase.
module cu9_lane_plan #(
    parameter int CODE_W = cu9_pkg::DEF_CODE_W,
    parameter int LANES  = cu9_pkg::DEF_LANES,
    parameter int LANE_W = cu9_pkg::DEF_LANE_W,
    localparam int LANE_BYTES = LANE_W / 8,
    localparam int SPAN       = (CODE_W + 14) / 8,
    localparam int SH_W       = $clog2(LANE_W)
) (
    input  logic [2:0]                      phase_i,
    output logic [LANES*LANE_BYTES*8-1:0]   sel_o,
    output logic [LANES*SH_W-1:0]           lsh_o,
    output logic [SH_W-1:0]                 rsh_o
);
    logic [7:0] first_byte [LANES];
    logic [2:0] bit_ofs    [LANES];
    logic [2:0] ofs_max;

    always_comb begin
        ofs_max = '0;
        for (int k = 0; k < LANES; k++) begin
            first_byte[k] = 8'((int'(phase_i) + CODE_W * k) / 8);
            bit_ofs[k]    = 3'((int'(phase_i) + CODE_W * k) % 8);
            if (bit_ofs[k] > ofs_max) begin
                ofs_max = bit_ofs[k];
            end
        end
    end

    genvar k, j;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            for (j = 0; j < LANE_BYTES; j++) begin : g_byte
                if (j < SPAN) begin : g_take
                    assign sel_o[(k*LANE_BYTES+j)*8 +: 8] = first_byte[k] + 8'(j);
                end else begin : g_zero
                    assign sel_o[(k*LANE_BYTES+j)*8 +: 8] = cu9_pkg::SEL_ZERO;
                end
            end
            assign lsh_o[k*SH_W +: SH_W] = SH_W'(ofs_max) - SH_W'(bit_ofs[k]);
        end
    endgenerate

    assign rsh_o = SH_W'(ofs_max);
endmodule

// File: rtl/cu9_byte_shuffle.sv
// Byte gather: each destination byte picks a source byte or zero (selector MSB set).
module cu9_byte_shuffle #(
    parameter int SRC_BYTES = 16,
    parameter int DST_BYTES = 16,
    localparam int IDX_W = $clog2(SRC_BYTES)
) (
    input  logic [SRC_BYTES*8-1:0] src_i,
    input  logic [DST_BYTES*8-1:0] sel_i,
    output logic [DST_BYTES*8-1:0] dst_o
);
    genvar j;
    generate
        for (j = 0; j < DST_BYTES; j++) begin : g_dst
            logic [7:0]       sel;
            logic [IDX_W-1:0] idx;
            assign sel = sel_i[j*8 +: 8];
            assign idx = sel[IDX_W-1:0];
            assign dst_o[j*8 +: 8] = sel[7] ? 8'h00 : src_i[idx*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/cu9_lane_align.sv
// Per-lane left shift, common right shift, code mask and invalid-lane clear.
module cu9_lane_align #(
    parameter int CODE_W = cu9_pkg::DEF_CODE_W,
    parameter int LANES  = cu9_pkg::DEF_LANES,
    parameter int LANE_W = cu9_pkg::DEF_LANE_W,
    localparam int SH_W  = $clog2(LANE_W)
) (
    input  logic [LANES*LANE_W-1:0] raw_i,
    input  logic [LANES*SH_W-1:0]   lsh_i,
    input  logic [SH_W-1:0]         rsh_i,
    input  logic [LANES-1:0]        keep_i,
    output logic [LANES*LANE_W-1:0] lanes_o
);
    localparam logic [LANE_W-1:0] CODE_MASK = LANE_W'((64'd1 << CODE_W) - 64'd1);

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            logic [LANE_W-1:0] lifted;
            logic [LANE_W-1:0] lowered;
            assign lifted  = raw_i[k*LANE_W +: LANE_W] << lsh_i[k*SH_W +: SH_W];
            assign lowered = lifted >> rsh_i;
            assign lanes_o[k*LANE_W +: LANE_W] = keep_i[k] ? (lowered & CODE_MASK) : '0;
        end
    endgenerate
endmodule

// File: rtl/col_unpack9.sv
module col_unpack9 #(
    parameter int IN_W   = cu9_pkg::DEF_IN_W,
    parameter int CODE_W = cu9_pkg::DEF_CODE_W,
    parameter int LANES  = cu9_pkg::DEF_LANES,
    parameter int LANE_W = cu9_pkg::DEF_LANE_W,
    parameter int BUF_W  = cu9_pkg::DEF_BUF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [IN_W-1:0]         in_data,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] out_lanes,
    output logic [LANES-1:0]        out_lane_vld,
    output logic                    out_last
);
    localparam int GROUP_BITS = CODE_W * LANES;
    localparam int CNT_W      = $clog2(BUF_W + 1);
    localparam int NC_W       = $clog2(LANES + 1);
    localparam int SH_W       = $clog2(LANE_W);
    localparam int WIN_BYTES  = IN_W / 8;
    localparam int OUT_BYTES  = LANES * LANE_W / 8;

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;       // bits held from buffer bit 0
        logic [2:0]       phase;     // consumed bits inside the first byte
        logic             tail;      // column end word is in the buffer
    } unp_state_t;

    unp_state_t st_q, st_d;

    logic [CNT_W-1:0] avail, adv, drop_bits, used_bits, rem_after, fit;
    logic [NC_W-1:0]  ncodes;
    logic             grp_ok, in_fire, out_fire;

    logic [OUT_BYTES*8-1:0]    sel;
    logic [LANES*SH_W-1:0]     lsh;
    logic [SH_W-1:0]           rsh;
    logic [LANES*LANE_W-1:0]   shuffled;

    always_comb begin
        avail     = st_q.cnt - CNT_W'(st_q.phase);
        grp_ok    = avail >= CNT_W'(GROUP_BITS);
        fit       = avail / CNT_W'(CODE_W);
        ncodes    = grp_ok ? NC_W'(LANES) : NC_W'(fit);
        used_bits = CNT_W'(ncodes) * CNT_W'(CODE_W);
        rem_after = avail - used_bits;
        adv       = CNT_W'(st_q.phase) + CNT_W'(GROUP_BITS);
        drop_bits = {adv[CNT_W-1:3], 3'b000};

        out_valid = grp_ok || (st_q.tail && (ncodes != '0));
        out_last  = st_q.tail && (rem_after < CNT_W'(CODE_W));
        for (int k = 0; k < LANES; k++) begin
            out_lane_vld[k] = NC_W'(k) < ncodes;
        end
        in_ready  = !st_q.tail && (st_q.cnt <= CNT_W'(BUF_W - IN_W));
        in_fire   = in_valid && in_ready;
        out_fire  = out_valid && out_ready;

        st_d = st_q;
        if (out_fire) begin
            if (out_last) begin
                st_d.bits  = '0;
                st_d.cnt   = '0;
                st_d.phase = '0;
                st_d.tail  = 1'b0;
            end else begin
                st_d.bits  = st_q.bits >> drop_bits;
                st_d.cnt   = st_q.cnt - drop_bits;
                st_d.phase = adv[2:0];
            end
        end else if (st_q.tail && !out_valid) begin
            // Column end with nothing left to emit: start the next column clean.
            st_d.bits  = '0;
            st_d.cnt   = '0;
            st_d.phase = '0;
            st_d.tail  = 1'b0;
        end
        if (in_fire) begin
            st_d.bits = st_d.bits | (BUF_W'(in_data) << st_d.cnt);
            st_d.cnt  = st_d.cnt + CNT_W'(IN_W);
            st_d.tail = in_last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cu9_lane_plan #(.CODE_W(CODE_W), .LANES(LANES), .LANE_W(LANE_W)) plan_i (
        .phase_i (st_q.phase),
        .sel_o   (sel),
        .lsh_o   (lsh),
        .rsh_o   (rsh)
    );

    cu9_byte_shuffle #(.SRC_BYTES(WIN_BYTES), .DST_BYTES(OUT_BYTES)) shuf_i (
        .src_i (st_q.bits[IN_W-1:0]),
        .sel_i (sel),
        .dst_o (shuffled)
    );

    cu9_lane_align #(.CODE_W(CODE_W), .LANES(LANES), .LANE_W(LANE_W)) align_i (
        .raw_i   (shuffled),
        .lsh_i   (lsh),
        .rsh_i   (rsh),
        .keep_i  (out_lane_vld),
        .lanes_o (out_lanes)
    );
endmodule

// File: rtl/cu9_checker.sv
module cu9_checker #(
    parameter int CODE_W = cu9_pkg::DEF_CODE_W,
    parameter int LANES  = cu9_pkg::DEF_LANES,
    parameter int LANE_W = cu9_pkg::DEF_LANE_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    in_last,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*LANE_W-1:0] out_lanes,
    input logic [LANES-1:0]        out_lane_vld,
    input logic                    out_last
);
    logic hi_dirty, void_dirty, mask_ok;

    always_comb begin
        hi_dirty   = 1'b0;
        void_dirty = 1'b0;
        mask_ok    = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            if ((out_lanes[k*LANE_W +: LANE_W] >> CODE_W) != '0) hi_dirty = 1'b1;
            if (!out_lane_vld[k] && out_lanes[k*LANE_W +: LANE_W] != '0) void_dirty = 1'b1;
        end
        for (int n = 1; n <= LANES; n++) begin
            if (out_lane_vld == LANES'((1 << n) - 1)) mask_ok = 1'b1;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_lanes)); // R7
    AST_LANE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !hi_dirty); // R1
    AST_MASK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mask_ok); // R6
    AST_VOID_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !void_dirty); // R6
    AST_PARTIAL_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(&out_lane_vld) |-> out_last); // R5
    AST_BLOCK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> !in_ready); // R4
endmodule

bind col_unpack9 cu9_checker #(.CODE_W(CODE_W), .LANES(LANES), .LANE_W(LANE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_last      (in_last),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_lanes    (out_lanes),
    .out_lane_vld (out_lane_vld),
    .out_last     (out_last)
);

// File: tb/col_unpack9_tb_top.sv
module col_unpack9_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic         rst_n, in_valid, in_ready, in_last, out_valid, out_ready, out_last;
    logic [127:0] in_data, out_lanes;
    logic [3:0]   out_lane_vld;

    int n_chk = 0, n_bad = 0, stall_mode = 0;
    bit done = 1'b0;

    typedef struct {
        logic [127:0] lanes;
        logic [3:0]   vld;
        logic         last;
        int           tag;
    } beat_t;
    beat_t exp_q[$];

    col_unpack9 dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_lanes(out_lanes),
        .out_lane_vld(out_lane_vld), .out_last(out_last)
    );

    function automatic string rq(int t);
        case (t)
            2:  return "R2";
            9:  return "R9";
            10: return "R10";
            default: return "R1";
        endcase
    endfunction

    task automatic note(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Builds the expected beats from the stream definition, then drives the words.
    task automatic send_column(input int nw, input int pat, input bit exact, input bit later);
        logic [1151:0] bits;
        int total, nc;
        bit acc;
        bits  = '0;
        total = nw * 128;
        nc    = total / 9;
        if (pat == 2) begin
            for (int i = 0; i < nc; i++) bits[9*i +: 9] = 9'((i * 37 + 5) % 512);
        end else begin
            for (int q = 0; q < nw * 4; q++) bits[32*q +: 32] = (pat == 0) ? $urandom : 32'hFFFF_FFFF;
        end
        for (int g = 0; g * 4 < nc; g++) begin
            beat_t b;
            b.lanes = '0;
            b.vld   = '0;
            b.tag   = 1;
            for (int k = 0; k < 4; k++) begin
                int i;
                i = 4 * g + k;
                if (i < nc) begin
                    b.lanes[32*k +: 32] = {23'd0, bits[9*i +: 9]};
                    b.vld[k] = 1'b1;
                    if ((9 * i) / 128 != (9 * i + 8) / 128) b.tag = 2;
                end
            end
            b.last = (4 * g + 4 >= nc);
            if (g == 0 && later) b.tag = 10;
            if (b.last && exact) b.tag = 9;
            exp_q.push_back(b);
        end
        for (int w = 0; w < nw; w++) begin
            in_data  = bits[128*w +: 128];
            in_last  = (w == nw - 1);
            in_valid = 1'b1;
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                acc = in_ready;
                @(posedge clk);
                #1;
            end
            in_valid = 1'b0;
            in_last  = 1'b0;
            repeat ($urandom_range(2)) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    initial out_ready = 1'b1;
    always @(posedge clk) begin
        #1;
        out_ready <= (stall_mode == 0) ? 1'b1 : ($urandom_range(3) != 0);
    end

    logic [127:0] prev_lanes;
    bit prev_stall = 1'b0;
    bit last_pend  = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_stall) note(out_valid && out_lanes == prev_lanes, "R7", out_lanes, prev_lanes);
            if (last_pend) note(!in_ready, "R4", 128'(in_ready), 128'd0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    note(1'b0, "R3", out_lanes, 128'd0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    note(out_lanes == e.lanes, rq(e.tag), out_lanes, e.lanes);
                    note(out_lane_vld == e.vld, "R6", 128'(out_lane_vld), 128'(e.vld));
                    note(out_last == e.last, (e.tag == 9) ? "R9" : "R5", 128'(out_last), 128'(e.last));
                end
                if (out_last) last_pend = 1'b0;
            end
            if (in_valid && in_ready && in_last) last_pend = 1'b1;
            prev_stall = out_valid && !out_ready;
            prev_lanes = out_lanes;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        note(!out_valid, "R8", 128'(out_valid), 128'd0);
        note(in_ready, "R8", 128'(in_ready), 128'd1);
        @(posedge clk);
        #1;
        send_column(1, 2, 1'b0, 1'b0);   // 14 codes, final mask 0011
        send_column(2, 0, 1'b0, 1'b1);   // 28 codes, full final beat, 4 bits dropped
        stall_mode = 1;
        send_column(9, 1, 1'b1, 1'b1);   // exactly 32 full beats
        send_column(5, 0, 1'b0, 1'b1);   // 71 codes, final mask 0111
        send_column(3, 2, 1'b0, 1'b1);
        send_column(9, 0, 1'b1, 1'b1);
        stall_mode = 0;
        send_column(1, 0, 1'b0, 1'b1);
        for (int t = 0; t < 4000 && exp_q.size() != 0; t++) @(posedge clk);
        repeat (3) @(posedge clk);
        @(negedge clk);
        note(exp_q.size() == 0, "R3", 128'(exp_q.size()), 128'd0);
        note(!out_valid, "R3", 128'(out_valid), 128'd0);
        note(in_ready, "R10", 128'(in_ready), 128'd1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R3: watchdog expired, actual %0d beats pending expected 0", exp_q.size());
            finish_run();
        end
    end
endmodule